// File: doc/BRIEF.md
# Cheater-Detecting Key Candidate Sequencer

During secret recovery, the participating cores rebuild a series of candidate keys one after another. The candidates are encoded so that every decoy is larger than the one before it. The genuine key is the only value that breaks this rising order. The sequencer takes the reconstructed candidates as a stream. It compares each candidate with the one before it. The first candidate that is strictly smaller than its predecessor is held as the recovered key. The key is released only when its round has been judged consistent, and the key output reads zero until then.

A round that takes all its candidates without any decrease points to a contributor that submitted a random share. The sequencer then starts the round again with one contributor left out, and it tries the eligible contributors in ascending index order. The first leave-one-out round that produces a decrease names the suspect. That contributor's bit is set in a persistent isolation mask, and the reconstruction logic uses this mask to exclude the contributor from all later recoveries. If no round produces a decrease, the sequencer raises an error instead of a key.

Top module: `key_candidate_seq`

## Requirements
- R1: After reset, key_valid, seq_err, cand_ready and omit_en are 0, key_out is all zero, and iso_mask is all zero.
- R2: The first candidate of a round only sets the baseline. Later candidates are compared with their predecessor as unsigned KEY_W-bit numbers. A value equal to its predecessor is not a decrease.
- R3: The first candidate that is strictly smaller than its predecessor ends the session. One cycle after that candidate is accepted, key_valid is 1 and key_out equals that candidate, and cand_ready is 0.
- R4: key_out is all zero whenever key_valid is 0.
- R5: A round that accepts M_CAND candidates without a decrease is followed by a leave-one-out round. omit_en is 1 in that round, and omit_idx names the lowest eligible contributor. For the first leave-out round, every non-isolated index is eligible. For later rounds, only non-isolated indices above the previous omit_idx are eligible.
- R6: A successful leave-out round sets bit omit_idx of iso_mask. iso_mask bits are never cleared except by reset, and they persist across sessions.
- R7: Leave-out rounds never omit an index whose iso_mask bit is already set.
- R8: If no eligible contributor remains after a failed round, seq_err is 1 and key_valid stays 0. key_valid and seq_err are never both 1.
- R9: A start pulse begins a new session from any state with omit_en 0. It clears key_valid and seq_err and sets key_out to zero, but it keeps iso_mask.
- R10: cand_valid while cand_ready is 0 is ignored. For example, a candidate sent after the key is released leaves key_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new recovery session |
| cand_valid | input | 1 | Reconstructed candidate present |
| cand_data | input | KEY_W | Reconstructed candidate value |
| cand_ready | output | 1 | Sequencer is accepting candidates for the current round |
| omit_en | output | 1 | Current round leaves one contributor out |
| omit_idx | output | IDX_W | Contributor left out when omit_en is 1 |
| key_valid | output | 1 | Recovered key is released |
| key_out | output | KEY_W | Recovered key, zero until released |
| seq_err | output | 1 | No consistent round was found |
| iso_mask | output | N_CORES | Contributors isolated as cheaters |

## Verification
Several properties are checked on every cycle. The key output stays dark until release, and the error and key flags are exclusive. The isolation mask only gains bits, one at a time. A round never omits an already isolated contributor. The key taken is the very candidate that caused the decrease. Other behaviour can only be shown by the bench scenarios. These include the unsigned order on values with the top bit set, equal values that do not count as a decrease, and the exact order in which contributors are left out. They also include the mask carrying into a later session and the error after every round has failed.

// File: rtl/kcs_pkg.sv
package kcs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GAP,
      ST_RUN,
      ST_DONE,
      ST_FAIL
   } kcs_state_e;
endpackage

// File: rtl/kcs_tracker.sv
module kcs_tracker #(
   parameter int KEY_W  = 128,
   parameter int M_CAND = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             take,
   input  logic [KEY_W-1:0] data,
   output logic             drop,
   output logic             last
);
   localparam int PW = (M_CAND > 2) ? $clog2(M_CAND) : 1;
   localparam logic [PW-1:0] LAST_POS = PW'(M_CAND - 1);

   logic [KEY_W-1:0] prev_q;
   logic [PW-1:0]    pos_q;

   // first candidate of a round only records the baseline
   assign drop = take && (pos_q != '0) && (data < prev_q);
   assign last = take && (pos_q == LAST_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pos_q  <= '0;
      end else if (clear) begin
         pos_q  <= '0;
      end else if (take) begin
         prev_q <= data;
         if (pos_q != LAST_POS) pos_q <= pos_q + 1'b1;
      end
   end

   p_pos_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= LAST_POS);
   p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> pos_q == '0);
endmodule

// File: rtl/kcs_pick.sv
module kcs_pick #(
   parameter int N_CORES = 4,
   parameter int IDX_W   = 2
) (
   input  logic [N_CORES-1:0] iso_mask,
   input  logic               omit_en,
   input  logic [IDX_W-1:0]   omit_idx,
   output logic               found,
   output logic [IDX_W-1:0]   next_idx
);
   logic [N_CORES-1:0] ok;

   for (genvar g = 0; g < N_CORES; g++) begin : g_ok
      assign ok[g] = !iso_mask[g] && (!omit_en || (IDX_W'(g) > omit_idx));
   end

   always_comb begin
      found    = 1'b0;
      next_idx = '0;
      for (int i = N_CORES - 1; i >= 0; i--) begin
         if (ok[i]) begin
            found    = 1'b1;
            next_idx = IDX_W'(i);
         end
      end
   end

   always_comb begin
      if (found) begin
         a_pick_free_r7: assert (!iso_mask[next_idx]);
      end
   end
endmodule

// File: rtl/key_candidate_seq.sv
module key_candidate_seq
   import kcs_pkg::*;
#(
   parameter int KEY_W   = 128,
   parameter int M_CAND  = 8,
   parameter int N_CORES = 4,
   localparam int IDX_W  = (N_CORES > 2) ? $clog2(N_CORES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               cand_valid,
   input  logic [KEY_W-1:0]   cand_data,
   output logic               cand_ready,
   output logic               omit_en,
   output logic [IDX_W-1:0]   omit_idx,
   output logic               key_valid,
   output logic [KEY_W-1:0]   key_out,
   output logic               seq_err,
   output logic [N_CORES-1:0] iso_mask
);
   if (M_CAND < 2) begin : g_bad_m
      $error("M_CAND must be at least 2");
   end
   if (N_CORES < 2) begin : g_bad_n
      $error("N_CORES must be at least 2");
   end
   if (KEY_W < 1) begin : g_bad_w
      $error("KEY_W must be positive");
   end

   kcs_state_e         state_q;
   logic               omit_en_q;
   logic [IDX_W-1:0]   omit_idx_q;
   logic [KEY_W-1:0]   key_q;
   logic [N_CORES-1:0] iso_q;
   logic               take, drop, last, found;
   logic [IDX_W-1:0]   next_idx;

   assign take = cand_valid && (state_q == ST_RUN);

   kcs_tracker #(.KEY_W(KEY_W), .M_CAND(M_CAND)) u_trk (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state_q == ST_GAP),
      .take  (take),
      .data  (cand_data),
      .drop  (drop),
      .last  (last)
   );

   kcs_pick #(.N_CORES(N_CORES), .IDX_W(IDX_W)) u_pick (
      .iso_mask (iso_q),
      .omit_en  (omit_en_q),
      .omit_idx (omit_idx_q),
      .found    (found),
      .next_idx (next_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         omit_en_q  <= 1'b0;
         omit_idx_q <= '0;
         key_q      <= '0;
         iso_q      <= '0;
      end else if (start) begin
         state_q    <= ST_GAP;
         omit_en_q  <= 1'b0;
         omit_idx_q <= '0;
         key_q      <= '0;
      end else begin
         case (state_q)
            ST_GAP: state_q <= ST_RUN;
            ST_RUN: begin
               if (drop) begin
                  key_q   <= cand_data;
                  state_q <= ST_DONE;
                  if (omit_en_q) iso_q[omit_idx_q] <= 1'b1;
               end else if (last) begin
                  if (found) begin
                     omit_en_q  <= 1'b1;
                     omit_idx_q <= next_idx;
                     state_q    <= ST_GAP;
                  end else begin
                     state_q <= ST_FAIL;
                  end
               end
            end
            default: state_q <= state_q;
         endcase
      end
   end

   assign cand_ready = (state_q == ST_RUN);
   assign omit_en    = omit_en_q;
   assign omit_idx   = omit_idx_q;
   assign key_valid  = (state_q == ST_DONE);
   assign key_out    = (state_q == ST_DONE) ? key_q : '0;
   assign seq_err    = (state_q == ST_FAIL);
   assign iso_mask   = iso_q;

   p_key_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !key_valid |-> key_out == '0);
   p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(key_valid && seq_err));
   p_mask_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (iso_mask & $past(iso_mask)) == $past(iso_mask));
   p_mask_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $countones(iso_mask ^ $past(iso_mask)) <= 1);
   p_omit_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_ready && omit_en) |-> !iso_mask[omit_idx]);
   p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid && cand_ready && drop && !start)
         |=> (key_valid && !cand_ready && key_out == $past(cand_data)));
endmodule

// File: tb/key_candidate_seq_test.sv
module key_candidate_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int KW = 128;
   localparam int NC = 4;

   typedef struct {
      logic          is_err;
      logic [KW-1:0] key;
      logic [NC-1:0] mask;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          cand_valid = 1'b0;
   logic [KW-1:0] cand_data = '0;
   logic          cand_ready, omit_en, key_valid, seq_err;
   logic [1:0]    omit_idx;
   logic [KW-1:0] key_out;
   logic [NC-1:0] iso_mask;

   int   total = 0;
   int   bad = 0;
   bit   finished = 1'b0;
   exp_t sb[$];
   logic kv_d = 1'b0, er_d = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   key_candidate_seq #(.KEY_W(KW), .M_CAND(4), .N_CORES(NC)) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cand_valid(cand_valid), .cand_data(cand_data),
      .cand_ready(cand_ready), .omit_en(omit_en), .omit_idx(omit_idx),
      .key_valid(key_valid), .key_out(key_out), .seq_err(seq_err),
      .iso_mask(iso_mask)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [KW-1:0] act, input logic [KW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(input logic e, input logic [KW-1:0] k, input logic [NC-1:0] m);
      exp_t x;
      x.is_err = e; x.key = k; x.mask = m;
      sb.push_back(x);
   endtask

   // monitor: compare each session outcome with the scoreboard
   always @(negedge clk) begin
      if (rst_n && ((key_valid && !kv_d) || (seq_err && !er_d))) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R3 unexpected outcome", KW'(key_out), '0);
         end else begin
            exp_t x;
            x = sb.pop_front();
            chk(seq_err == x.is_err, "R8 outcome kind", KW'(seq_err), KW'(x.is_err));
            chk(key_out == x.key, "R3 key", key_out, x.key);
            chk(iso_mask == x.mask, "R6 mask", KW'(iso_mask), KW'(x.mask));
         end
      end
      kv_d <= key_valid;
      er_d <= seq_err;
   end

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_round(input logic en, input int idx, input string req);
      while (!cand_ready) @(negedge clk);
      chk(omit_en == en, req, KW'(omit_en), KW'(en));
      if (en) chk(omit_idx == idx[1:0], req, KW'(omit_idx), KW'(idx));
   endtask

   task automatic send(input logic [KW-1:0] v);
      cand_valid = 1'b1;
      cand_data  = v;
      @(negedge clk);
      cand_valid = 1'b0;
   endtask

   task automatic fail_round(input logic en, input int idx, input string req);
      wait_round(en, idx, req);
      for (int i = 1; i <= 4; i++) send(KW'(i));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!key_valid && !seq_err && !cand_ready && !omit_en, "R1 flags",
          KW'({key_valid, seq_err, cand_ready, omit_en}), '0);
      chk(key_out == '0 && iso_mask == '0, "R1 key/mask", key_out, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // session A: plain round, genuine key at the fourth position
      push(1'b0, KW'(5), 4'b0000);
      pulse_start();
      wait_round(1'b0, 0, "R9 first round all cores");
      send(KW'(10)); send(KW'(20)); send(KW'(30));
      chk(key_out == '0, "R4 dark before key", key_out, '0);
      send(KW'(5));
      chk(!cand_ready, "R3 stop after decrease", KW'(cand_ready), '0);
      send(KW'(1));
      chk(key_out == KW'(5), "R10 ignored candidate", key_out, KW'(5));

      // session B: equal values, then leave-outs, unsigned compare
      push(1'b0, KW'(5), 4'b0010);
      pulse_start();
      chk(key_out == '0 && !key_valid, "R9 key cleared", key_out, '0);
      wait_round(1'b0, 0, "R9 omit off");
      for (int i = 0; i < 4; i++) send(KW'(7));   // R2 equal is no decrease
      fail_round(1'b1, 0, "R5 first omit index");
      wait_round(1'b1, 1, "R5 next omit index");
      send(KW'(3));
      send({1'b1, {(KW-1){1'b0}}});
      chk(key_out == '0, "R2 top-bit value is larger", key_out, '0);
      send(KW'(5));
      @(negedge clk);

      // session C: mask persists, isolated index skipped
      push(1'b0, KW'(8), 4'b0110);
      pulse_start();
      chk(iso_mask == 4'b0010, "R9 mask kept", KW'(iso_mask), KW'(4'b0010));
      fail_round(1'b0, 0, "R9 round zero");
      fail_round(1'b1, 0, "R7 omit zero");
      wait_round(1'b1, 2, "R7 skip isolated one");
      send(KW'(9)); send(KW'(8));
      @(negedge clk);

      // session D: every round fails
      push(1'b1, '0, 4'b0110);
      pulse_start();
      fail_round(1'b0, 0, "R8 round zero");
      fail_round(1'b1, 0, "R8 omit zero");
      fail_round(1'b1, 3, "R7 skip isolated one and two");
      @(negedge clk);
      chk(seq_err && !key_valid && key_out == '0, "R8 error no key",
          key_out, '0);
      chk(sb.size() == 0, "R8 all outcomes seen", KW'(sb.size()), '0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule